// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This controller gathers 32 interrupt sources and hands the processor one prepared request. Each source can be raised by its hardware line or by a software request bit. A source is pending only when its enable bit is also set. Each source carries a programmed 6-bit priority level, a non-maskable flag and a register-set number. Every clock the controller chooses the pending source with the highest level. It works out where that source's handler sits in a vector table and registers a request packet for the core: handler address, register set, level, non-maskable flag and a request strobe.

Software reaches the controller through a single-cycle word port. The byte address is decoded on bits [7:2] into 64 word slots, of which 44 are defined. The enable mask and the software request mask can be written in three ways: overwritten whole, or changed by setting or clearing only the bits that are written as ones. The table base and the per-entry stride are programmable, and the block reports the current winner and its computed vector through two read-only words.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While reset is asserted and after its release, every configuration word, the stride field, raw status, enable, software requests, table base, status and vector address read 0; reqValid, the packet fields and busRdata are 0.
- R2: Per-source word n (word indices 0 to 31) holds level in bits [5:0], the non-maskable flag in bit 6 and register set in bits [12:7]; reads return those 13 bits with bits [31:13] zero.
- R3: Word 36 returns the interrupt lines as sampled on the previous clock edge; word 35 returns (word 36 OR word 37) AND word 32.
- R4: Word 32 (enable) and word 37 (software requests) are overwritten by a write; a write to word 33 or 38 ORs the data into enable or software requests respectively; a write to word 34 or 39 clears the bits that are written as ones.
- R5: The winner is the pending source with the strictly greatest level; equal levels go to the lower index, and a level-0 source never wins.
- R6: The handler address is winner_index × (1 << (2 + word40[2:0])) + word42, taken modulo 2^32; only bits [2:0] of word 40 are stored.
- R7: With a winner, word 41 reads bit 31 set and the winner index in bits [4:0] (other bits zero) and word 43 reads the handler address; with no winner both read 0.
- R8: With a winner, reqValid is 1 and reqHandler, reqRegSet, reqLevel and reqNmi carry the winner's values; with no winner all five outputs are 0.
- R9: The packet, word 41 and word 43 after clock edge k reflect the interrupt lines sampled at edge k and the register contents as they stood before any write taken at edge k.
- R10: A read with busValid=1 and busWrite=0 returns its data on busRdata after the next edge. Reads of words 33, 34, 38, 39 and 44 to 63 return 0. Writes to words 35, 36, 41, 43 and 44 to 63 change nothing. busRdata is 0 after any edge that took no read.
- R11: A software request bit set in word 37 competes in the priority selection exactly like a hardware line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address; bits [7:2] pick the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| irqLines | input | 32 | Hardware interrupt lines, level sensitive, synchronous to clk |
| reqValid | output | 1 | Request to the processor |
| reqHandler | output | 32 | Handler address of the winning source |
| reqRegSet | output | 6 | Register set requested by the winner |
| reqLevel | output | 6 | Level of the winner |
| reqNmi | output | 1 | Non-maskable flag of the winner |

## Verification
A register write and a change of the interrupt lines can land on the same clock edge. For example, the enable of the current winner can be cleared, or a level can be raised, in the same cycle that a new line rises. The bench provokes this both in directed steps and by driving random line patterns together with random writes over thousands of cycles. A behavioural model applies the write only after it has scored that edge, and every cycle's packet and read data are compared with it. This checks that the packet follows the new lines and the old register contents, with the write showing one edge later.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned NUM_SRC   = 32;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned WORD_W    = ADDR_W - 2;
  localparam int unsigned IDX_W     = $clog2(NUM_SRC);
  localparam int unsigned LVL_W     = 6;
  localparam int unsigned RS_W      = 6;
  localparam int unsigned STRIDE_W  = 3;
  localparam int unsigned NMI_BIT   = LVL_W;
  localparam int unsigned RS_LSB    = LVL_W + 1;
  localparam int unsigned CFG_W     = RS_LSB + RS_W;
  localparam int unsigned BASE_SHIFT = 2;

  typedef logic [WORD_W-1:0] word_t;
  localparam word_t W_EN      = word_t'(NUM_SRC + 0);
  localparam word_t W_EN_SET  = word_t'(NUM_SRC + 1);
  localparam word_t W_EN_CLR  = word_t'(NUM_SRC + 2);
  localparam word_t W_PEND    = word_t'(NUM_SRC + 3);
  localparam word_t W_RAW     = word_t'(NUM_SRC + 4);
  localparam word_t W_SW      = word_t'(NUM_SRC + 5);
  localparam word_t W_SW_SET  = word_t'(NUM_SRC + 6);
  localparam word_t W_SW_CLR  = word_t'(NUM_SRC + 7);
  localparam word_t W_GCFG    = word_t'(NUM_SRC + 8);
  localparam word_t W_STATUS  = word_t'(NUM_SRC + 9);
  localparam word_t W_BASE    = word_t'(NUM_SRC + 10);
  localparam word_t W_VEC     = word_t'(NUM_SRC + 11);

  typedef struct packed {
    logic             cfgWr;
    logic [IDX_W-1:0] cfgIdx;
    logic             enWr;
    logic             enSet;
    logic             enClr;
    logic             swWr;
    logic             swSet;
    logic             swClr;
    logic             gcfgWr;
    logic             baseWr;
    logic             rdEn;
    word_t            rdWord;
  } vic_strobe_t;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
    logic [LVL_W-1:0] level;
  } vic_win_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output vic_strobe_t       strb
);
  word_t word;
  logic  wrAcc;

  assign word  = busAddr[ADDR_W-1:2];
  assign wrAcc = busValid & busWrite;

  always_comb begin
    strb        = '0;
    strb.rdEn   = busValid & ~busWrite;
    strb.rdWord = word;
    strb.cfgIdx = word[IDX_W-1:0];
    if (wrAcc) begin
      if (word < word_t'(NUM_SRC)) begin
        strb.cfgWr = 1'b1;
      end else begin
        case (word)
          W_EN:     strb.enWr   = 1'b1;
          W_EN_SET: strb.enSet  = 1'b1;
          W_EN_CLR: strb.enClr  = 1'b1;
          W_SW:     strb.swWr   = 1'b1;
          W_SW_SET: strb.swSet  = 1'b1;
          W_SW_CLR: strb.swClr  = 1'b1;
          W_GCFG:   strb.gcfgWr = 1'b1;
          W_BASE:   strb.baseWr = 1'b1;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
(
  input  logic [NUM_SRC-1:0]            pending,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] levels,
  output vic_win_t                      win
);
  logic [NUM_SRC-1:0][LVL_W-1:0] effLvl;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_eff
    assign effLvl[s] = pending[s] ? levels[s] : '0;
  end

  always_comb begin
    logic [LVL_W-1:0] bestLvl;
    logic [IDX_W-1:0] bestIdx;
    bestLvl = '0;
    bestIdx = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (effLvl[s] > bestLvl) begin
        bestLvl = effLvl[s];
        bestIdx = IDX_W'(s);
      end
    end
    win.valid = (bestLvl != '0);
    win.idx   = bestIdx;
    win.level = bestLvl;
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  vic_strobe_t       strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_SRC-1:0] irqLines,
  output logic [DATA_W-1:0] rdata,
  output logic              reqValid,
  output logic [DATA_W-1:0] reqHandler,
  output logic [RS_W-1:0]   reqRegSet,
  output logic [LVL_W-1:0]  reqLevel,
  output logic              reqNmi
);
  logic [LVL_W-1:0]    cfgLvl [NUM_SRC];
  logic [RS_W-1:0]     cfgRs  [NUM_SRC];
  logic [NUM_SRC-1:0]  cfgNmi;
  logic [NUM_SRC-1:0]  enReg, swReg, rawReg;
  logic [STRIDE_W-1:0] gcfgReg;
  logic [DATA_W-1:0]   baseReg, statusReg, vecReg;

  logic [NUM_SRC-1:0]            pendLive;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvlPacked;
  vic_win_t                      win;
  logic [STRIDE_W:0]             shiftAmt;
  logic [DATA_W-1:0]             handlerNext;
  logic [DATA_W-1:0]             rdNext;

  // configuration words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        cfgLvl[s] <= '0;
        cfgRs[s]  <= '0;
      end
      cfgNmi <= '0;
    end else if (strb.cfgWr) begin
      cfgLvl[strb.cfgIdx] <= wdata[LVL_W-1:0];
      cfgRs[strb.cfgIdx]  <= wdata[RS_LSB +: RS_W];
      cfgNmi[strb.cfgIdx] <= wdata[NMI_BIT];
    end
  end

  // masks, raw capture, global words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      swReg   <= '0;
      rawReg  <= '0;
      gcfgReg <= '0;
      baseReg <= '0;
    end else begin
      rawReg <= irqLines;
      if (strb.enWr)       enReg <= wdata[NUM_SRC-1:0];
      else if (strb.enSet) enReg <= enReg | wdata[NUM_SRC-1:0];
      else if (strb.enClr) enReg <= enReg & ~wdata[NUM_SRC-1:0];
      if (strb.swWr)       swReg <= wdata[NUM_SRC-1:0];
      else if (strb.swSet) swReg <= swReg | wdata[NUM_SRC-1:0];
      else if (strb.swClr) swReg <= swReg & ~wdata[NUM_SRC-1:0];
      if (strb.gcfgWr)     gcfgReg <= wdata[STRIDE_W-1:0];
      if (strb.baseWr)     baseReg <= wdata;
    end
  end

  // priority selection on live lines and current registers
  assign pendLive = (irqLines | swReg) & enReg;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) lvlPacked[s] = cfgLvl[s];
  end

  vic_arbiter u_arb (
    .pending (pendLive),
    .levels  (lvlPacked),
    .win     (win)
  );

  assign shiftAmt    = {1'b0, gcfgReg} + (STRIDE_W+1)'(BASE_SHIFT);
  assign handlerNext = (DATA_W'(win.idx) << shiftAmt) + baseReg;

  // registered request packet and derived status words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid   <= 1'b0;
      reqHandler <= '0;
      reqRegSet  <= '0;
      reqLevel   <= '0;
      reqNmi     <= 1'b0;
      statusReg  <= '0;
      vecReg     <= '0;
    end else if (win.valid) begin
      reqValid   <= 1'b1;
      reqHandler <= handlerNext;
      reqRegSet  <= cfgRs[win.idx];
      reqLevel   <= win.level;
      reqNmi     <= cfgNmi[win.idx];
      statusReg  <= {1'b1, (DATA_W-1-IDX_W)'(0), win.idx};
      vecReg     <= handlerNext;
    end else begin
      reqValid   <= 1'b0;
      reqHandler <= '0;
      reqRegSet  <= '0;
      reqLevel   <= '0;
      reqNmi     <= 1'b0;
      statusReg  <= '0;
      vecReg     <= '0;
    end
  end

  // read multiplexer
  always_comb begin
    rdNext = '0;
    if (strb.rdEn) begin
      if (strb.rdWord < word_t'(NUM_SRC)) begin
        rdNext = DATA_W'({cfgRs[strb.rdWord[IDX_W-1:0]],
                          cfgNmi[strb.rdWord[IDX_W-1:0]],
                          cfgLvl[strb.rdWord[IDX_W-1:0]]});
      end else begin
        case (strb.rdWord)
          W_EN:     rdNext = DATA_W'(enReg);
          W_PEND:   rdNext = DATA_W'((rawReg | swReg) & enReg);
          W_RAW:    rdNext = DATA_W'(rawReg);
          W_SW:     rdNext = DATA_W'(swReg);
          W_GCFG:   rdNext = DATA_W'(gcfgReg);
          W_STATUS: rdNext = statusReg;
          W_BASE:   rdNext = baseReg;
          W_VEC:    rdNext = vecReg;
          default:  rdNext = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else       rdata <= rdNext;
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] irqLines,
  output logic               reqValid,
  output logic [DATA_W-1:0]  reqHandler,
  output logic [RS_W-1:0]    reqRegSet,
  output logic [LVL_W-1:0]   reqLevel,
  output logic               reqNmi
);
  vic_strobe_t strb;

  vic_ctrl u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  vic_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wdata      (busWdata),
    .irqLines   (irqLines),
    .rdata      (busRdata),
    .reqValid   (reqValid),
    .reqHandler (reqHandler),
    .reqRegSet  (reqRegSet),
    .reqLevel   (reqLevel),
    .reqNmi     (reqNmi)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic [NUM_SRC-1:0] irqLines,
  input logic               reqValid,
  input logic [DATA_W-1:0]  reqHandler,
  input logic [RS_W-1:0]    reqRegSet,
  input logic [LVL_W-1:0]   reqLevel,
  input logic               reqNmi
);
  logic  armed;
  word_t accWord;
  logic  deadRead;

  assign accWord  = busAddr[ADDR_W-1:2];
  assign deadRead = busValid && !busWrite &&
                    (accWord == W_EN_SET || accWord == W_EN_CLR ||
                     accWord == W_SW_SET || accWord == W_SW_CLR ||
                     accWord > W_VEC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!reqValid && busRdata == '0 && reqHandler == '0);
    end
  end

  assert_idle_packet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (reqHandler == '0 && reqRegSet == '0 && reqLevel == '0 && !reqNmi));

  assert_nmi_needs_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqNmi |-> reqValid);

  assert_winner_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqLevel != '0);

  assert_dead_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(deadRead)) |-> busRdata == '0);

  assert_noread_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(!(busValid && !busWrite))) |-> busRdata == '0);
endmodule

bind vec_irq_ctrl vic_checker u_chk (.*);

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] irqLines = '0;
  logic        reqValid;
  logic [31:0] reqHandler;
  logic [5:0]  reqRegSet;
  logic [5:0]  reqLevel;
  logic        reqNmi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #HALF clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqLines(irqLines), .reqValid(reqValid), .reqHandler(reqHandler),
    .reqRegSet(reqRegSet), .reqLevel(reqLevel), .reqNmi(reqNmi)
  );

  // behavioural reference state
  int          mLvl [32];
  int          mRs  [32];
  bit          mNmi [32];
  logic [31:0] mEn, mSw, mRaw, mBase, mStatus, mVec;
  int          mStride;

  function automatic void modelReset();
    for (int i = 0; i < 32; i++) begin mLvl[i] = 0; mRs[i] = 0; mNmi[i] = 0; end
    mEn = 0; mSw = 0; mRaw = 0; mBase = 0; mStatus = 0; mVec = 0; mStride = 0;
  endfunction

  function automatic logic [31:0] modelRead(int w);
    if (w < 32) return 32'(mRs[w]) * 128 + (mNmi[w] ? 32'd64 : 32'd0) + 32'(mLvl[w]);
    case (w)
      32: return mEn;
      35: return (mRaw | mSw) & mEn;
      36: return mRaw;
      37: return mSw;
      40: return 32'(mStride);
      41: return mStatus;
      42: return mBase;
      43: return mVec;
      default: return 32'd0;
    endcase
  endfunction

  function automatic void modelWrite(int w, logic [31:0] d);
    if (w < 32) begin
      mLvl[w] = int'(d[5:0]); mNmi[w] = d[6]; mRs[w] = int'(d[12:7]);
      return;
    end
    case (w)
      32: mEn = d;
      33: mEn = mEn | d;
      34: mEn = mEn & ~d;
      37: mSw = d;
      38: mSw = mSw | d;
      39: mSw = mSw & ~d;
      40: mStride = int'(d[2:0]);
      42: mBase = d;
      default: ;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one bus cycle with full packet and read comparison
  task automatic step(bit v, bit w, int word, logic [31:0] d, logic [31:0] lines, string tag);
    int best; int bestLvl; logic [31:0] pend;
    logic [31:0] eHandler; bit eValid; int eRs; int eLvl; bit eNmi; logic [31:0] eRd;
    @(negedge clk);
    busValid = v; busWrite = w; busAddr = 8'(word * 4); busWdata = d; irqLines = lines;
    pend = (lines | mSw) & mEn;
    best = -1; bestLvl = 0;
    for (int i = 0; i < 32; i++)
      if (pend[i] && mLvl[i] > bestLvl) begin best = i; bestLvl = mLvl[i]; end
    eValid = (best >= 0);
    eHandler = eValid ? 32'(best) * (32'd1 << (2 + mStride)) + mBase : 32'd0;
    eRs  = eValid ? mRs[best] : 0;
    eLvl = bestLvl;
    eNmi = eValid ? mNmi[best] : 1'b0;
    eRd  = (v && !w) ? modelRead(word) : 32'd0;
    if (v && w) modelWrite(word, d);
    mRaw    = lines;
    mStatus = eValid ? (32'h8000_0000 | 32'(best)) : 32'd0;
    mVec    = eHandler;
    @(posedge clk);
    #2;
    check(tag, "reqValid",   32'(reqValid),  32'(eValid));
    check(tag, "reqHandler", reqHandler,     eHandler);
    check(tag, "reqRegSet",  32'(reqRegSet), 32'(eRs));
    check(tag, "reqLevel",   32'(reqLevel),  32'(eLvl));
    check(tag, "reqNmi",     32'(reqNmi),    32'(eNmi));
    check(tag, "busRdata",   busRdata,       eRd);
  endtask

  task automatic wr(int word, logic [31:0] d, logic [31:0] lines, string tag);
    step(1, 1, word, d, lines, tag);
  endtask
  task automatic rd(int word, logic [31:0] lines, string tag);
    step(1, 0, word, 0, lines, tag);
  endtask
  task automatic idle(logic [31:0] lines, string tag);
    step(0, 0, 0, 0, lines, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(2 * HALF * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1", "reset reqValid", 32'(reqValid), 0);
    check("R1", "reset busRdata", busRdata, 0);
    rstN = 1'b1;
    // R1: every defined word reads zero after reset
    for (int w = 0; w < 44; w++) rd(w, 0, "R1");

    // R2: config fields, upper bits dropped
    wr(3, 32'hFFFF_E000 | (32'h2A << 7) | 32'h40 | 32'd5, 0, "R2");
    rd(3, 0, "R2");
    wr(20, 32'd63, 0, "R2");
    wr(2, 32'd9 | (32'd1 << 7), 0, "R2");
    wr(7, 32'd9 | (32'd2 << 7), 0, "R2");
    wr(1, 32'd0 | 32'h40, 0, "R2");
    rd(20, 0, "R2");

    // R4: enable overwrite / set / clear, software masks
    wr(32, 32'h0000_0008, 0, "R4");
    wr(33, 32'h0000_0010, 0, "R4");
    wr(34, 32'h0000_0008, 0, "R4");
    rd(32, 0, "R4");
    wr(38, 32'h0000_0300, 0, "R4");
    wr(39, 32'h0000_0100, 0, "R4");
    rd(37, 0, "R4");
    wr(37, 32'h0, 0, "R4");
    rd(37, 0, "R4");
    wr(32, 32'hFFFF_FFFF, 0, "R4");

    // R5: level-0 never wins, tie to lower index, highest level wins
    idle(32'h0000_0002, "R5");
    idle(32'h0000_0084, "R5");
    idle(32'h0010_0084, "R5");
    idle(32'h0000_0088, "R5");
    idle(32'h0000_0000, "R5");

    // R6 / R7: stride and base, with wraparound
    wr(40, 32'hFFFF_FFFF, 32'h0010_0000, "R6");
    wr(42, 32'hFFFF_FF00, 32'h0010_0000, "R6");
    idle(32'h0010_0000, "R6");
    rd(40, 32'h0010_0000, "R6");
    rd(41, 32'h0010_0000, "R7");
    rd(43, 32'h0010_0000, "R7");
    wr(40, 32'h2, 32'h0000_0080, "R6");
    idle(32'h0000_0080, "R6");
    rd(43, 0, "R7");
    rd(41, 0, "R7");
    rd(43, 0, "R7");

    // R8: register set and non-maskable flag of the winner
    idle(32'h0000_0008, "R8");
    idle(32'h0000_0008, "R8");

    // R3: raw capture and pending mask
    wr(32, 32'h0000_00F0, 32'h0000_0FF0, "R3");
    rd(36, 32'h0000_0FF0, "R3");
    rd(35, 32'h0000_0FF0, "R3");

    // R11: software request competes like a line
    wr(38, 32'h0000_0080, 32'h0, "R11");
    idle(32'h0, "R11");
    rd(35, 32'h0, "R11");
    wr(39, 32'h0000_0080, 32'h0, "R11");
    idle(32'h0, "R11");

    // R9: write and line change on the same edge
    wr(32, 32'hFFFF_FFFF, 32'h0000_0004, "R9");
    wr(34, 32'h0000_0004, 32'h0010_0004, "R9");
    wr(20, 32'd1, 32'h0010_0004, "R9");
    idle(32'h0010_0004, "R9");

    // R10: dead reads, ignored writes, rdata idle zero
    rd(33, 32'h0010_0000, "R10");
    rd(34, 0, "R10");
    rd(38, 0, "R10");
    rd(39, 0, "R10");
    rd(44, 0, "R10");
    rd(63, 0, "R10");
    wr(35, 32'hFFFF_FFFF, 32'h0000_0080, "R10");
    wr(36, 32'hFFFF_FFFF, 32'h0000_0080, "R10");
    wr(41, 32'hFFFF_FFFF, 32'h0000_0080, "R10");
    wr(43, 32'hFFFF_FFFF, 32'h0000_0080, "R10");
    wr(50, 32'hFFFF_FFFF, 32'h0000_0080, "R10");
    rd(41, 32'h0000_0080, "R10");
    rd(43, 32'h0000_0080, "R10");
    rd(36, 32'h0000_0080, "R10");
    idle(32'h0000_0080, "R10");

    // R9: random concurrent traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int kind; int word; logic [31:0] d; logic [31:0] lines;
      kind  = int'($urandom_range(0, 3));
      word  = int'($urandom_range(0, 63));
      d     = $urandom();
      lines = $urandom() & $urandom();
      case (kind)
        0: idle(lines, "R9");
        1: rd(word, lines, "R9");
        default: wr(word, d, lines, "R9");
      endcase
    end

    finishRun();
  end
endmodule